// File: doc/BRIEF.md
# Processor Status Word Unit

This block holds the processor status word and updates it after every ALU operation. Each cycle the datapath presents a result, the two operands, the carry-out of the low half and the carry-out of the full word, an operation class and a byte/word select. The unit then derives the four condition flags: carry, zero, negative and overflow. In byte mode it takes them from the low half of the word, and in word mode from the full word. The flags stay in the register for the jump logic and for software to read.

The same register also holds the control bits that only software may change. These are the global interrupt enable, the CPU-off and oscillator-off bits, and two clock-generator bits. Together with the on/off bits, the clock-generator bits select the low-power mode. A software write port can load every defined bit at once. When a software write and an automatic flag update fall in the same cycle, the software write wins. The upper seven bits carry no state and always read as zero.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears the whole status word to 0x0000, so every individual flag output reads 0.
- R2: After an add, subtract or logical operation, the zero flag (bit 1) is 1 exactly when the result bits of the selected width are all zero. Byte mode looks at bits 7:0 only; word mode looks at bits 15:0.
- R3: After an add, subtract or logical operation, the negative flag (bit 2) equals result bit 7 in byte mode and result bit 15 in word mode.
- R4: After an add or subtract, the carry flag (bit 0) equals `alu_cy_half` in byte mode and `alu_cy_full` in word mode.
- R5: After an add, the overflow flag (bit 8) is 1 exactly when the operands have the same sign and the result's sign differs from it, with sign taken at bit 7 (byte) or bit 15 (word).
- R6: After a subtract (`src_a` minus `src_b`), the overflow flag is the add rule applied to `src_a` and the negated `src_b`. Overflow is set when the operand signs differ and the result's sign differs from that of `src_a`.
- R7: After a logical operation, the overflow flag is cleared and the carry flag is the inverse of the new zero flag. The carry inputs are ignored.
- R8: Operation class 0 (no update), with no software write, leaves the whole status word unchanged.
- R9: The control bits change only by a software write. These are interrupt enable (bit 3), CPU-off (bit 4), oscillator-off (bit 5) and the clock-generator bits (bits 6 and 7). Operations never change them, and they appear on `gie`, `cpu_off`, `osc_off` and `clk_gen`.
- R10: Status bits 15:9 always read as zero, whatever value a software write places on `sw_data[15:9]`.
- R11: When `sw_we` is high, bits 8:0 take `sw_data[8:0]` at the next edge. Any operation presented in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alu_res | input | 16 | ALU result of the current operation |
| src_a | input | 16 | First operand (minuend for subtract) |
| src_b | input | 16 | Second operand (subtrahend for subtract) |
| alu_cy_half | input | 1 | Carry-out of bit 7 (no-borrow for subtract) |
| alu_cy_full | input | 1 | Carry-out of bit 15 (no-borrow for subtract) |
| op_sel | input | 2 | Operation class: 0 none, 1 add, 2 subtract, 3 logical |
| byte_mode | input | 1 | 1 selects byte width, 0 word width |
| sw_we | input | 1 | Software write strobe |
| sw_data | input | 16 | Software write data |
| status | output | 16 | Full status word |
| flag_c | output | 1 | Carry flag (bit 0) |
| flag_z | output | 1 | Zero flag (bit 1) |
| flag_n | output | 1 | Negative flag (bit 2) |
| flag_v | output | 1 | Overflow flag (bit 8) |
| gie | output | 1 | Global interrupt enable (bit 3) |
| cpu_off | output | 1 | CPU-off control (bit 4) |
| osc_off | output | 1 | Oscillator-off control (bit 5) |
| clk_gen | output | 2 | Clock-generator control (bits 7:6) |

## Verification
Every write to the status word reaches the ports one edge later, so a wrong flag shows on the status output in the cycle right after the operation that produced it. An error in a flag rule stays in the register until the next update. A control bit that is wrongly disturbed stays wrong until software rewrites it, so a disturbance caused by an arithmetic operation remains visible over many later cycles. The bench mixes byte and word operations whose upper byte disagrees with the low byte. This exposes a flag taken from the wrong bit on the first such operation.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
package sfr_pkg;

  typedef enum logic [1:0] {
    OPC_NONE  = 2'd0,
    OPC_ADD   = 2'd1,
    OPC_SUB   = 2'd2,
    OPC_LOGIC = 2'd3
  } op_class_e;

  // bit positions inside the status word
  localparam int unsigned POS_C      = 0;
  localparam int unsigned POS_Z      = 1;
  localparam int unsigned POS_N      = 2;
  localparam int unsigned POS_GIE    = 3;
  localparam int unsigned POS_CPUOFF = 4;
  localparam int unsigned POS_OSCOFF = 5;
  localparam int unsigned POS_CG_LO  = 6;
  localparam int unsigned POS_CG_HI  = 7;
  localparam int unsigned POS_V      = 8;
  localparam int unsigned DEF_BITS   = 9;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } cond_flags_t;

endpackage

// File: rtl/flag_eval.sv
`timescale 1ns/1ps
module flag_eval
  import sfr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] res,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              cy_half,
  input  logic              cy_full,
  input  logic              byte_sel,
  input  op_class_e         op,
  output cond_flags_t       flags,
  output logic              upd
);

  localparam int unsigned HALF_W = DATA_W / 2;

  function automatic logic sel_msb(input logic [DATA_W-1:0] v, input logic bsel);
    return bsel ? v[HALF_W-1] : v[DATA_W-1];
  endfunction

  function automatic logic sel_zero(input logic [DATA_W-1:0] v, input logic bsel);
    return bsel ? (v[HALF_W-1:0] == '0) : (v == '0);
  endfunction

  // signs equal on the inputs, result sign differs
  function automatic logic ovf_sum(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                                   input logic [DATA_W-1:0] r, input logic bsel);
    logic sa, sb, sr;
    sa = sel_msb(a, bsel);
    sb = sel_msb(b, bsel);
    sr = sel_msb(r, bsel);
    return (sa == sb) && (sr != sa);
  endfunction

  // difference: the sum rule on the inverted subtrahend
  function automatic logic ovf_diff(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                                    input logic [DATA_W-1:0] r, input logic bsel);
    return ovf_sum(a, ~b, r, bsel);
  endfunction

  logic res_zero, res_neg, cy_sel, v_add, v_sub;

  assign res_zero = sel_zero(res, byte_sel);
  assign res_neg  = sel_msb(res, byte_sel);
  assign cy_sel   = byte_sel ? cy_half : cy_full;
  assign v_add    = ovf_sum(opa, opb, res, byte_sel);
  assign v_sub    = ovf_diff(opa, opb, res, byte_sel);

  always_comb begin
    flags.z = res_zero;
    flags.n = res_neg;
    flags.c = cy_sel;
    flags.v = 1'b0;
    upd     = 1'b1;
    unique case (op)
      OPC_ADD:   flags.v = v_add;
      OPC_SUB:   flags.v = v_sub;
      OPC_LOGIC: begin
        flags.v = 1'b0;
        flags.c = ~res_zero;
      end
      default:   upd = 1'b0;
    endcase
  end

endmodule

// File: rtl/status_core.sv
`timescale 1ns/1ps
module status_core
  import sfr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  cond_flags_t       flags,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_data,
  output logic [DATA_W-1:0] status
);

  localparam int unsigned PAD_W = DATA_W - DEF_BITS;

  logic [DEF_BITS-1:0] word_q;
  logic                auto_take;

  assign auto_take = upd & ~sw_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (sw_we) begin
      word_q <= sw_data[DEF_BITS-1:0];
    end else if (auto_take) begin
      word_q[POS_C] <= flags.c;
      word_q[POS_Z] <= flags.z;
      word_q[POS_N] <= flags.n;
      word_q[POS_V] <= flags.v;
    end
  end

  assign status = {{PAD_W{1'b0}}, word_q};

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (status == '0));

  p_sw_prio_r11: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (status[DEF_BITS-1:0] == $past(sw_data[DEF_BITS-1:0])));

  p_ctrl_only_sw_r9: assert property (@(posedge clk) disable iff (rst)
    !sw_we |=> $stable(status[POS_CG_HI:POS_GIE]));

  p_hold_none_r8: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && !upd) |=> $stable(status));

  p_hi_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (sw_we && (|sw_data[DATA_W-1:DEF_BITS])) |=> (status[DATA_W-1:DEF_BITS] == '0));

endmodule

// File: rtl/status_flag_unit.sv
`timescale 1ns/1ps
module status_flag_unit
  import sfr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              alu_cy_half,
  input  logic              alu_cy_full,
  input  logic [1:0]        op_sel,
  input  logic              byte_mode,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_data,
  output logic [DATA_W-1:0] status,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_v,
  output logic              gie,
  output logic              cpu_off,
  output logic              osc_off,
  output logic [1:0]        clk_gen
);

  localparam int unsigned HALF_W = DATA_W / 2;

  op_class_e   op_cls;
  cond_flags_t nxt_flags;
  logic        flag_upd;

  assign op_cls = op_class_e'(op_sel);

  flag_eval #(.DATA_W(DATA_W)) u_eval (
    .res      (alu_res),
    .opa      (src_a),
    .opb      (src_b),
    .cy_half  (alu_cy_half),
    .cy_full  (alu_cy_full),
    .byte_sel (byte_mode),
    .op       (op_cls),
    .flags    (nxt_flags),
    .upd      (flag_upd)
  );

  status_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .upd     (flag_upd),
    .flags   (nxt_flags),
    .sw_we   (sw_we),
    .sw_data (sw_data),
    .status  (status)
  );

  assign flag_c  = status[POS_C];
  assign flag_z  = status[POS_Z];
  assign flag_n  = status[POS_N];
  assign flag_v  = status[POS_V];
  assign gie     = status[POS_GIE];
  assign cpu_off = status[POS_CPUOFF];
  assign osc_off = status[POS_OSCOFF];
  assign clk_gen = status[POS_CG_HI:POS_CG_LO];

  p_logic_rule_r7: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && op_cls == OPC_LOGIC) |=> (!flag_v && (flag_c == !flag_z)));

  p_neg_width_r3: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && flag_upd) |=>
      (flag_n == $past(byte_mode ? alu_res[HALF_W-1] : alu_res[DATA_W-1])));

  p_zero_byte_r2: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && flag_upd && byte_mode && alu_res[HALF_W-1:0] == '0) |=> flag_z);

  p_carry_sel_r4: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && (op_cls == OPC_ADD || op_cls == OPC_SUB)) |=>
      (flag_c == $past(byte_mode ? alu_cy_half : alu_cy_full)));

endmodule

// File: tb/tb_status_flag_unit.sv
`timescale 1ns/1ps
module tb_status_flag_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] alu_res, src_a, src_b, sw_data, status;
  logic        alu_cy_half, alu_cy_full, byte_mode, sw_we;
  logic [1:0]  op_sel, clk_gen;
  logic        flag_c, flag_z, flag_n, flag_v, gie, cpu_off, osc_off;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic [15:0] model = 16'h0000;

  always #5 clk = ~clk;

  status_flag_unit dut (
    .clk(clk), .rst(rst), .alu_res(alu_res), .src_a(src_a), .src_b(src_b),
    .alu_cy_half(alu_cy_half), .alu_cy_full(alu_cy_full), .op_sel(op_sel),
    .byte_mode(byte_mode), .sw_we(sw_we), .sw_data(sw_data), .status(status),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .gie(gie), .cpu_off(cpu_off), .osc_off(osc_off), .clk_gen(clk_gen)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // signed overflow test by integer range, independent of sign-bit rules
  function automatic logic ovf_int(input logic [15:0] a, input logic [15:0] b,
                                   input logic is_sub, input logic bsel);
    int sa, sb, s;
    sa = bsel ? int'($signed(a[7:0])) : int'($signed(a));
    sb = bsel ? int'($signed(b[7:0])) : int'($signed(b));
    s  = is_sub ? sa - sb : sa + sb;
    if (bsel) return (s > 127) || (s < -128);
    return (s > 32767) || (s < -32768);
  endfunction

  task automatic check_ports(input string tag);
    chk({tag, " R9 ctrl"}, {11'd0, clk_gen, osc_off, cpu_off, gie}, {11'd0, model[7:3]});
    chk({tag, " R10 upper"}, {7'd0, status[15:9]}, 16'd0);
  endtask

  // op: 0 none, 1 add, 2 sub, 3 logical (xor)
  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic [1:0] op,
                        input logic bsel, input logic we, input logic [15:0] wd);
    logic [16:0] full;
    logic [8:0]  half;
    logic [15:0] r;
    logic        c8, c16, z, n, c, v;
    r = $urandom; c8 = $urandom; c16 = $urandom;
    case (op)
      2'd1: begin
        full = {1'b0, a} + {1'b0, b}; half = {1'b0, a[7:0]} + {1'b0, b[7:0]};
        r = full[15:0]; c16 = full[16]; c8 = half[8];
      end
      2'd2: begin
        r = a - b; c16 = (a >= b); c8 = (a[7:0] >= b[7:0]);
      end
      2'd3: r = a ^ b;
      default: ;
    endcase
    @(negedge clk);
    src_a = a; src_b = b; alu_res = r; alu_cy_half = c8; alu_cy_full = c16;
    op_sel = op; byte_mode = bsel; sw_we = we; sw_data = wd;
    @(posedge clk);
    #1;
    if (we) begin
      model = {7'd0, wd[8:0]};
      chk("R11 sw write priority", status, model);
      check_ports("R11");
    end else if (op == 2'd0) begin
      chk("R8 no-update hold", status, model);
      check_ports("R8");
    end else begin
      z = bsel ? (r[7:0] == 8'd0) : (r == 16'd0);
      n = bsel ? r[7] : r[15];
      c = (op == 2'd3) ? !z : (bsel ? c8 : c16);
      v = (op == 2'd3) ? 1'b0 : ovf_int(a, b, op == 2'd2, bsel);
      model[0] = c; model[1] = z; model[2] = n; model[8] = v;
      chk("R2 zero", {15'd0, flag_z}, {15'd0, z});
      chk("R3 negative", {15'd0, flag_n}, {15'd0, n});
      if (op == 2'd3) begin
        chk("R7 logical carry", {15'd0, flag_c}, {15'd0, c});
        chk("R7 logical overflow", {15'd0, flag_v}, 16'd0);
      end else begin
        chk("R4 carry", {15'd0, flag_c}, {15'd0, c});
        chk(op == 2'd1 ? "R5 add overflow" : "R6 sub overflow", {15'd0, flag_v}, {15'd0, v});
      end
      chk("R9 full word", status, model);
      check_ports("op");
    end
    sw_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; alu_res = 0; src_a = 0; src_b = 0; alu_cy_half = 0; alu_cy_full = 0;
    op_sel = 0; byte_mode = 0; sw_we = 0; sw_data = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset clear", status, 16'h0000);
    @(negedge clk); rst = 1'b0;
    run_op(0, 0, 2'd0, 0, 1'b1, 16'hFFFF);      // load all ones, upper ignored
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    model = 16'h0000;
    chk("R1 reset clears ones", status, 16'h0000);
    chk("R1 flag ports", {8'd0, clk_gen, osc_off, cpu_off, gie, flag_v, flag_n, flag_z, flag_c}, 16'd0);
    @(negedge clk); rst = 1'b0;

    // directed corners
    run_op(16'h7FFF, 16'h0001, 2'd1, 0, 0, 0);  // word add overflow, negative
    run_op(16'h017F, 16'h0001, 2'd1, 1, 0, 0);  // byte add overflow from bit 7
    run_op(16'h0180, 16'h0080, 2'd1, 1, 0, 0);  // byte zero with upper nonzero, carry
    run_op(16'h8000, 16'h0001, 2'd2, 0, 0, 0);  // word sub overflow
    run_op(16'h0000, 16'h0001, 2'd2, 1, 0, 0);  // byte borrow, negative
    run_op(16'h0080, 16'h007F, 2'd2, 1, 0, 0);  // byte sub overflow
    run_op(16'h5A5A, 16'h5A5A, 2'd3, 0, 0, 0);  // logical zero -> carry clear
    run_op(16'h1200, 16'h3400, 2'd3, 1, 0, 0);  // byte logical zero, upper nonzero
    run_op(16'h8001, 16'h0000, 2'd3, 0, 0, 0);  // logical nonzero -> carry set
    run_op(16'h1234, 16'h4321, 2'd0, 0, 0, 0);  // no update
    run_op(16'hFFFF, 16'hFFFF, 2'd1, 0, 1'b1, 16'hFEF8); // write beats add
    run_op(16'h7FFF, 16'h7FFF, 2'd1, 0, 0, 0);  // control bits stay
    run_op(16'h0000, 16'h0000, 2'd2, 0, 0, 0);

    for (int i = 0; i < 1200; i++) begin
      int unsigned k;
      k = $urandom % 10;
      run_op($urandom, $urandom, 2'($urandom), 1'($urandom), k == 0, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule